// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers 33 interrupt sources and presents them to a processor core as two request lines. A fast request line carries exactly one source, chosen by software, and that source outranks everything else. A general request line is shared by 32 lines, numbered 0 to 31, which are resolved by fixed priority where the lower index wins. Lines 0 to 31 can feed either path. Source 32 can reach only the fast path, when software selects it.

Software works through a small register port with a strobe, a write flag, an address and data. Through this port it selects the fast source, masks general lines, chooses edge or level sensing per source, reads raw pending status and the winning line index, and acknowledges edge-latched lines. The fast request, the general request and the winning index are all registered, so each one reflects the inputs of the previous clock.

Top module: `dual_intc`

## Requirements
- R1: After reset, both request outputs are 0, the vector output is 63 (all ones), all 32 mask bits read as 1 (masked), the fast-select field reads 32, and every source is level-sensed.
- R2: The fast request goes high one clock after the source named by the fast-select field (register address 0, bits [5:0]) becomes pending. The general mask has no effect on it.
- R3: A line in 0..31 that is named by the fast-select field takes no part in general arbitration, and it never appears on the vector output.
- R4: Among the general lines that are pending, unmasked and not routed to the fast path, the lowest index wins the vector output.
- R5: A line whose mask bit (address 1, bit n, 1 = masked) is set does not raise the general request and does not appear in the vector. It still shows in the status register (address 3, bit n = raw pending).
- R6: The general request is 1 exactly when the vector output is not 63. The vector reads 63 when no candidate line is pending.
- R7: A line set to edge mode (address 2, bit n = 1 for lines 0..31, and address 0 bit 8 for source 32) becomes pending on a rising input. It stays pending after the input falls, until a write to address 5 with the line index in bits [5:0] clears it.
- R8: A level-mode line is pending exactly while its input is high. An acknowledge write has no effect on it.
- R9: The request and vector outputs update one clock after a change at the inputs or in the configuration: they are unchanged before the next rising edge and updated after it.
- R10: A fast-select value above 32 leaves the fast request low. Source 32 never drives the general request.
- R11: When a rising edge and an acknowledge of the same edge-mode line fall in the same cycle, the line stays pending.
- R12: A read strobe (write flag low) returns the addressed register on the read-data port after the next rising edge. Address 4 returns the current vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 33 | Interrupt source inputs; bit 32 is the fast-only source |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| fiq_o | output | 1 | Fast request |
| irq_o | output | 1 | General request |
| vec_o | output | 6 | Winning general line index, 63 when none |

## Verification
A table of source, mask and fast-select patterns drives the priority resolution. Two pending lines, with and without the lower one masked, tell lowest-index-wins apart from highest-index-wins and from a resolver that ignores the mask. Patterns that route a pending line to the fast path while a higher index is also pending show whether the routed line is taken out of arbitration. Out-of-range selects and a lone source 32 show whether the fast-only source leaks onto the general path. Directed sequences then cover the difference between edge and level sensing under acknowledge, a rising edge that coincides with its acknowledge, the one-cycle output latency, and readback.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W    = 3;
  localparam int MODE32_BIT = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_FIQSEL = 3'd0,
    A_MASK   = 3'd1,
    A_MODE   = 3'd2,
    A_STATUS = 3'd3,
    A_VECTOR = 3'd4,
    A_ACK    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = NUM_IRQ + 1,
  parameter int SEL_W   = $clog2(NUM_SRC),
  parameter int VEC_W   = SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] status_i,
  input  logic [VEC_W-1:0]   vector_i,
  output logic [SEL_W-1:0]   fiq_sel_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic we, re, ack_we;
  assign we     = valid_i && write_i;
  assign re     = valid_i && !write_i;
  assign ack_we = we && (addr_i == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_sel_o <= SEL_W'(NUM_IRQ);
      mask_o    <= '1;
      mode_o    <= '0;
    end else if (we) begin
      case (addr_i)
        A_FIQSEL: begin
          fiq_sel_o        <= wdata_i[SEL_W-1:0];
          mode_o[NUM_IRQ]  <= wdata_i[MODE32_BIT];
        end
        A_MASK:  mask_o <= wdata_i[NUM_IRQ-1:0];
        A_MODE:  mode_o[NUM_IRQ-1:0] <= wdata_i[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_clr
      assign clr_o[g] = ack_we && (wdata_i[SEL_W-1:0] == SEL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (re) begin
      case (addr_i)
        A_FIQSEL: begin
          rdata_o <= DATA_W'(fiq_sel_o);
          rdata_o[MODE32_BIT] <= mode_o[NUM_IRQ];
        end
        A_MASK:   rdata_o <= DATA_W'(mask_o);
        A_MODE:   rdata_o <= DATA_W'(mode_o[NUM_IRQ-1:0]);
        A_STATUS: rdata_o <= DATA_W'(status_i);
        A_VECTOR: rdata_o <= DATA_W'(vector_i);
        default:  rdata_o <= '0;
      endcase
    end
  end

  // R1: reset leaves every line masked and source 32 on the fast path
  assert_reset_cfg_R1: assert property (@(posedge clk)
    $past(rst) |-> (mask_o == '1 && fiq_sel_o == SEL_W'(NUM_IRQ) && mode_o == '0));
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_SRC = 33
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mode_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, edge_q, rise;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_line
      assign rise[g] = src_i[g] && !src_q[g];
      always_ff @(posedge clk) begin
        if (rst) begin
          src_q[g]  <= 1'b0;
          edge_q[g] <= 1'b0;
        end else begin
          src_q[g]  <= src_i[g];
          edge_q[g] <= mode_i[g] && ((edge_q[g] && !clr_i[g]) || rise[g]);
        end
      end
      assign pend_o[g] = mode_i[g] ? (edge_q[g] || rise[g]) : src_i[g];
    end
  endgenerate

  // R7: an acknowledge without a coinciding rise leaves the latch empty
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_q & $past(clr_i & ~rise)) == '0);
  // R11: a rise on an edge line always latches, acknowledge or not
  assert_rise_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (($past(rise & mode_i) & ~mode_i) | ($past(rise & mode_i) & edge_q)) == $past(rise & mode_i));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  logic [N-1:0] below;
  assign below = ({{(N-1){1'b0}}, 1'b1} << idx_o) - 1'b1;

  always_comb begin
    if (found_o) begin
      // R4: winner is requesting and nothing below it is
      assert_lowest_wins_R4: assert (req_i[idx_o] && ((req_i & below) == '0));
    end
  end
endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  localparam int NUM_SRC = NUM_IRQ + 1,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int IDX_W   = $clog2(NUM_IRQ),
  localparam int VEC_W   = SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_valid_i,
  input  logic               reg_write_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               fiq_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam logic [VEC_W-1:0] VEC_NONE = '1;

  logic [SEL_W-1:0]   fiq_sel;
  logic [NUM_IRQ-1:0] mask;
  logic [NUM_SRC-1:0] mode, clr, pend, fiq_hit;
  logic [NUM_IRQ-1:0] cand;
  logic               found;
  logic [IDX_W-1:0]   idx;

  intc_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .valid_i(reg_valid_i), .write_i(reg_write_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(pend[NUM_IRQ-1:0]),
    .vector_i(vec_o), .fiq_sel_o(fiq_sel), .mask_o(mask), .mode_o(mode),
    .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .src_i(src_i), .mode_i(mode), .clr_i(clr), .pend_o(pend)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_sel
      assign fiq_hit[g] = (fiq_sel == SEL_W'(g));
    end
  endgenerate

  assign cand = pend[NUM_IRQ-1:0] & ~mask & ~fiq_hit[NUM_IRQ-1:0];

  intc_prio #(.N(NUM_IRQ)) u_prio (.req_i(cand), .found_o(found), .idx_o(idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
      vec_o <= VEC_NONE;
    end else begin
      fiq_o <= |(pend & fiq_hit);
      irq_o <= |cand;
      vec_o <= found ? VEC_W'(idx) : VEC_NONE;
    end
  end

  // R6: request and vector agree
  assert_irq_vec_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vec_o != VEC_NONE));
  // R3: the fast-routed line never wins general arbitration
  assert_vec_not_fiq_R3: assert property (@(posedge clk) disable iff (rst)
    (vec_o != VEC_NONE) |-> ($past(fiq_sel) != SEL_W'(vec_o)));
  // R5: the winner was unmasked
  assert_vec_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
    (vec_o != VEC_NONE) |-> !(($past(mask) >> vec_o[IDX_W-1:0]) & 1'b1));
  // R10: fast request only with an in-range select
  assert_fiq_range_R10: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> ($past(fiq_sel) < SEL_W'(NUM_SRC)));
endmodule

// File: tb/dual_intc_tb.sv
module dual_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [32:0] src = '0;
  logic        rv = 1'b0, rw = 1'b0;
  logic [2:0]  ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        fiq, irq;
  logic [5:0]  vec;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dual_intc u_dut (
    .clk(clk), .rst(rst), .src_i(src), .reg_valid_i(rv), .reg_write_i(rw),
    .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .fiq_o(fiq), .irq_o(irq), .vec_o(vec)
  );

  localparam int NV = 10;
  localparam logic [32:0] T_SRC [NV] = '{33'h0, 33'h220, 33'h220, 33'h0_8000_0000,
    33'h0_8000_0001, 33'h1_0000_0000, 33'h1_0000_0000, 33'h0_FFFF_FFFF, 33'h88, 33'h0_FFFF_0000};
  localparam logic [31:0] T_MSK [NV] = '{32'h0, 32'h0, 32'h20, 32'h0, 32'h0,
    32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFE, 32'h0, 32'h0000_FFFF};
  localparam logic [5:0] T_SEL [NV] = '{6'd32, 6'd32, 6'd32, 6'd32, 6'd0, 6'd32, 6'd40, 6'd0, 6'd3, 6'd33};
  localparam logic T_IRQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic T_FIQ [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [5:0] T_VEC [NV] = '{6'd63, 6'd5, 6'd9, 6'd31, 6'd31, 6'd63, 6'd63, 6'd63, 6'd7, 6'd16};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); rv = 1'b1; rw = 1'b1; ra = a; wd = d;
    @(posedge clk);
    @(negedge clk); rv = 1'b0; rw = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rv = 1'b1; rw = 1'b0; ra = a;
    @(posedge clk);
    @(negedge clk); rv = 1'b0; d = rd;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 fiq", 32'(fiq), 0);
    check("R1 vec", 32'(vec), 63);
    rdreg(3'd1, r); check("R1 mask", r, 32'hFFFF_FFFF);
    rdreg(3'd0, r); check("R1 fiqsel", r, 32);
    rdreg(3'd2, r); check("R1 mode", r, 0);

    // Table: R2 R3 R4 R5 R6 R10 under level sensing
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, T_MSK[i]);
      wr(3'd0, 32'(T_SEL[i]));
      src = T_SRC[i];
      settle();
      check($sformatf("R4/R3 vec row%0d", i), 32'(vec), 32'(T_VEC[i]));
      check($sformatf("R6/R5 irq row%0d", i), 32'(irq), 32'(T_IRQ[i]));
      check($sformatf("R2/R10 fiq row%0d", i), 32'(fiq), 32'(T_FIQ[i]));
    end

    // R9 latency
    src = '0;
    wr(3'd1, 32'h0);
    wr(3'd0, 32'd32);
    settle();
    @(negedge clk); src[10] = 1'b1;
    #1 check("R9 before edge", 32'(irq), 0);
    @(negedge clk);
    check("R9 after edge irq", 32'(irq), 1);
    check("R9 after edge vec", 32'(vec), 10);
    // R12 vector readback
    rdreg(3'd4, r); check("R12 vector read", r, 10);
    // R5 masked line still in status
    wr(3'd1, 32'h0000_0400);
    settle();
    check("R5 masked irq", 32'(irq), 0);
    rdreg(3'd3, r); check("R5 status", r, 32'h0000_0400);
    src[10] = 1'b0;

    // R7 edge latch and acknowledge
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0000_0010);
    @(negedge clk); src[4] = 1'b1;
    @(negedge clk); src[4] = 1'b0;
    settle();
    check("R7 latched vec", 32'(vec), 4);
    check("R7 latched irq", 32'(irq), 1);
    wr(3'd5, 32'd4);
    @(negedge clk);
    check("R7 after ack vec", 32'(vec), 63);

    // R11 rise and ack same cycle
    @(negedge clk); src[4] = 1'b1; rv = 1'b1; rw = 1'b1; ra = 3'd5; wd = 32'd4;
    @(negedge clk); rv = 1'b0; rw = 1'b0;
    settle();
    check("R11 stays pending", 32'(vec), 4);
    src[4] = 1'b0;

    // R8 level line ignores acknowledge
    src[6] = 1'b1;
    wr(3'd5, 32'd4);
    wr(3'd5, 32'd6);
    settle();
    check("R8 level after ack", 32'(vec), 6);
    src[6] = 1'b0;
    settle();
    check("R8 level drops", 32'(irq), 0);

    // R7 edge on source 32 via fast path
    wr(3'd0, 32'h0000_0120);
    @(negedge clk); src[32] = 1'b1;
    @(negedge clk); src[32] = 1'b0;
    settle();
    check("R7 fast edge held", 32'(fiq), 1);
    wr(3'd5, 32'd32);
    @(negedge clk);
    check("R7 fast edge acked", 32'(fiq), 0);
    rdreg(3'd0, r); check("R12 fiqsel read", r, 32'h120);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule